// File: doc/BRIEF.md
# Accumulator-Immediate Microcoded ALU Sequencer

This block executes one class of instruction: an ALU operation between a 16-bit accumulator and an immediate constant. Its input is a byte stream with a valid/acknowledge handshake. The first byte of each instruction is the opcode. One immediate byte follows for the byte form, and two follow for the word form, low byte first.

Control comes from a four-entry micro-program held in an internal ROM. The micro-program is generic. The opcode supplies the ALU function, the operand width and the accumulator view: the full accumulator for word operations, its low half for byte operations. The steps are as follows:
- Two steps move stream bytes into operand register B.
- One step copies the accumulator into operand register A. This step also starts the ALU and raises a near-end pulse.
- The last step writes the result back, updates the flags and raises an end pulse.

A micro-branch on the first step skips the high-byte load for byte operations. The branch costs one bubble cycle, so both forms take the same time.

The near-end pulse lets the sequencer accept the next opcode during the final step of the current instruction. A continuous stream therefore completes one instruction every four cycles.

Top module: `accseq_top`

## Requirements
- R1: After synchronous reset the accumulator and all flags are 0, and `near_end_o`, `end_o` and `s_ack` are low while `s_valid` is low.
- R2: An opcode byte is taken only when the sequencer is idle or in the cycle where `end_o` is high. Opcode bits [5:3] select the function: 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare. Opcode bit 0 selects byte (0) or word (1). `s_ack` is never high without `s_valid`.
- R3: Word form: the opcode is followed by the low and then the high immediate byte, and the result replaces all 16 accumulator bits.
- R4: Byte form: the opcode is followed by one immediate byte. The operation uses only accumulator bits [7:0], and accumulator bits [15:8] are unchanged.
- R5: With the stream always valid, `near_end_o` is high 3 cycles after the cycle in which the opcode is acknowledged and `end_o` is high 4 cycles after it. `end_o` always follows `near_end_o` by exactly one cycle.
- R6: For a byte operation the micro-branch inserts one bubble cycle, in which no stream byte is acknowledged. The byte form therefore has the same 4-cycle timing as the word form.
- R7: If no stream byte is valid in a step that loads an immediate byte, the sequencer holds that step. `end_o` is delayed by exactly the number of stalled cycles.
- R8: The flag output carries four flags: bit 0 is carry/borrow, bit 1 is zero, bit 2 is sign and bit 3 is signed overflow. All four are computed at the selected width. Or, and and xor clear carry and overflow.
- R9: Add-with-carry adds the current carry flag. Subtract-with-borrow subtracts the current carry flag.
- R10: Compare sets the flags exactly as subtract would but leaves the accumulator unchanged.
- R11: With a continuous stream, the next opcode is acknowledged in the same cycle that `end_o` is high, so instructions run back to back.
- R12: The accumulator and the flags change only on the clock edge that ends a cycle in which `end_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream byte is valid |
| s_data | input | 8 | Stream byte (opcode or immediate) |
| s_ack | output | 1 | Stream byte consumed at this clock edge |
| acc_o | output | 16 | Accumulator |
| flag_o | output | 4 | Flags {overflow, sign, zero, carry} |
| near_end_o | output | 1 | Next-to-last micro-step of the instruction |
| end_o | output | 1 | Final micro-step: result and flags written at this edge |

## Verification
The assertions assume that the stream source obeys the handshake. A byte it offers stays stable until it is acknowledged. Its byte sequence is a well-formed list of opcode-plus-immediate instructions, never a truncated one.

The stimulus meets this by changing `s_data` and `s_valid` only at the falling edge, and only after the previous byte was acknowledged. It always sends complete instructions and withholds bytes only as explicit gap cycles before an instruction's immediate bytes. The expected stall length for each instruction is therefore known exactly.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

    localparam int WORD_W  = 16;
    localparam int HALF_W  = WORD_W / 2;
    localparam int UADDR_W = 2;
    localparam int FLAG_W  = 4;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_OR  = 3'd1,
        ALU_ADC = 3'd2,
        ALU_SBB = 3'd3,
        ALU_AND = 3'd4,
        ALU_SUB = 3'd5,
        ALU_XOR = 3'd6,
        ALU_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_BUBBLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic                take_lo;
        logic                take_hi;
        logic                load_a;
        logic                br_byte;
        logic [UADDR_W-1:0]  br_tgt;
        logic                near_end;
        logic                fin;
    } uinst_t;

    typedef struct packed {
        logic ov;
        logic sign;
        logic zero;
        logic carry;
    } flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == ALU_ADD) || (op == ALU_ADC) || (op == ALU_SUB) ||
               (op == ALU_SBB) || (op == ALU_CMP);
    endfunction

    function automatic logic is_subtract(alu_op_e op);
        return (op == ALU_SUB) || (op == ALU_SBB) || (op == ALU_CMP);
    endfunction

endpackage

// File: rtl/accseq_urom.sv
module accseq_urom
    import accseq_pkg::*;
(
    input  logic [UADDR_W-1:0] uaddr,
    output uinst_t             uop
);
    localparam logic [UADDR_W-1:0] STEP_ALU = UADDR_W'(2);

    always_comb begin
        uop = '0;
        case (uaddr)
            UADDR_W'(0): begin
                uop.take_lo = 1'b1;
                uop.br_byte = 1'b1;
                uop.br_tgt  = STEP_ALU;
            end
            UADDR_W'(1): uop.take_hi = 1'b1;
            UADDR_W'(2): begin
                uop.load_a   = 1'b1;
                uop.near_end = 1'b1;
            end
            default: uop.fin = 1'b1;
        endcase
    end
endmodule

// File: rtl/accseq_ctrl.sv
module accseq_ctrl
    import accseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               s_valid,
    input  logic               word_op,
    input  uinst_t             uop,
    output logic [UADDR_W-1:0] uaddr,
    output logic               s_ack,
    output logic               accept_op,
    output logic               lo_en,
    output logic               hi_en,
    output logic               load_a_en,
    output logic               near_end,
    output logic               fin
);
    phase_e phase;
    logic   run, need_byte, fetch_ok;

    assign run       = (phase == PH_RUN);
    assign need_byte = run && (uop.take_lo || uop.take_hi);
    assign fetch_ok  = (phase == PH_IDLE) || (run && uop.fin);
    assign s_ack     = s_valid && (need_byte || fetch_ok);
    assign accept_op = s_valid && fetch_ok;
    assign lo_en     = run && uop.take_lo && s_valid;
    assign hi_en     = run && uop.take_hi && s_valid;
    assign load_a_en = run && uop.load_a;
    assign near_end  = run && uop.near_end;
    assign fin       = run && uop.fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            uaddr <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (s_valid) begin
                        phase <= PH_RUN;
                        uaddr <= '0;
                    end
                end
                PH_BUBBLE: phase <= PH_RUN;
                default: begin
                    if (uop.fin) begin
                        uaddr <= '0;
                        if (!s_valid) phase <= PH_IDLE;
                    end else if (need_byte && !s_valid) begin
                        uaddr <= uaddr;
                    end else if (uop.br_byte && !word_op) begin
                        phase <= PH_BUBBLE;
                        uaddr <= uop.br_tgt;
                    end else begin
                        uaddr <= uaddr + UADDR_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/accseq_alu.sv
module accseq_alu
    import accseq_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic         word_op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output flags_t       flg
);
    localparam int H = W / 2;

    logic [W:0] ea, eb, r;
    logic       arith, subtr, ma, mb, mr;

    always_comb begin
        ea = word_op ? {1'b0, a} : {{(W-H+1){1'b0}}, a[H-1:0]};
        eb = word_op ? {1'b0, b} : {{(W-H+1){1'b0}}, b[H-1:0]};
        case (op)
            ALU_ADD: r = ea + eb;
            ALU_ADC: r = ea + eb + {{W{1'b0}}, cin};
            ALU_SUB,
            ALU_CMP: r = ea - eb;
            ALU_SBB: r = ea - eb - {{W{1'b0}}, cin};
            ALU_OR:  r = ea | eb;
            ALU_AND: r = ea & eb;
            default: r = ea ^ eb;
        endcase
        arith = is_arith(op);
        subtr = is_subtract(op);
        ma    = word_op ? ea[W-1] : ea[H-1];
        mb    = word_op ? eb[W-1] : eb[H-1];
        mr    = word_op ? r[W-1]  : r[H-1];
        res       = r[W-1:0];
        flg.carry = arith && (word_op ? r[W] : r[H]);
        flg.zero  = word_op ? (r[W-1:0] == '0) : (r[H-1:0] == '0);
        flg.sign  = mr;
        flg.ov    = arith && (subtr ? ((ma != mb) && (mr != ma))
                                    : ((ma == mb) && (mr != ma)));
    end
endmodule

// File: rtl/accseq_top.sv
module accseq_top
    import accseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [HALF_W-1:0] s_data,
    output logic              s_ack,
    output logic [WORD_W-1:0] acc_o,
    output logic [FLAG_W-1:0] flag_o,
    output logic              near_end_o,
    output logic              end_o
);
    localparam int W = WORD_W;
    localparam int H = HALF_W;

    logic [UADDR_W-1:0] uaddr;
    uinst_t             uop;
    logic               accept_op, lo_en, hi_en, load_a_en, fin;
    alu_op_e            op_q;
    logic               word_q;
    logic [W-1:0]       acc_q, tmp_a, tmp_b, alu_res;
    flags_t             flags_q, alu_flg;

    accseq_urom u_rom (.uaddr(uaddr), .uop(uop));

    accseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .s_valid(s_valid), .word_op(word_q), .uop(uop),
        .uaddr(uaddr), .s_ack(s_ack), .accept_op(accept_op), .lo_en(lo_en),
        .hi_en(hi_en), .load_a_en(load_a_en), .near_end(near_end_o), .fin(fin)
    );

    accseq_alu #(.W(W)) u_alu (
        .op(op_q), .word_op(word_q), .a(tmp_a), .b(tmp_b),
        .cin(flags_q.carry), .res(alu_res), .flg(alu_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= ALU_ADD;
            word_q  <= 1'b0;
            acc_q   <= '0;
            tmp_a   <= '0;
            tmp_b   <= '0;
            flags_q <= '0;
        end else begin
            if (accept_op) begin
                op_q   <= alu_op_e'(s_data[5:3]);
                word_q <= s_data[0];
            end
            if (lo_en) tmp_b <= {{(W-H){1'b0}}, s_data};
            if (hi_en) tmp_b[W-1:H] <= s_data;
            if (load_a_en) tmp_a <= word_q ? acc_q : {{(W-H){1'b0}}, acc_q[H-1:0]};
            if (fin) begin
                flags_q <= alu_flg;
                if (op_q != ALU_CMP)
                    acc_q <= word_q ? alu_res : {acc_q[W-1:H], alu_res[H-1:0]};
            end
        end
    end

    assign acc_o  = acc_q;
    assign flag_o = flags_q;
    assign end_o  = fin;
endmodule

// File: rtl/accseq_chk.sv
module accseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_valid,
    input logic        s_ack,
    input logic        near_end_o,
    input logic        end_o,
    input logic [15:0] acc,
    input logic [3:0]  flg,
    input logic [2:0]  op
);
    // R2
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        s_ack |-> s_valid);

    // R5
    near_then_end_chk: assert property (@(posedge clk) disable iff (rst)
        near_end_o |=> end_o);

    // R5
    end_after_near_chk: assert property (@(posedge clk) disable iff (rst)
        end_o |-> $past(near_end_o));

    // R6
    no_take_near_end_chk: assert property (@(posedge clk) disable iff (rst)
        near_end_o |-> !s_ack);

    // R12
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !end_o |=> $stable(acc));

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !end_o |=> $stable(flg));

    // R10
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (end_o && op == 3'd7) |=> $stable(acc));
endmodule

bind accseq_top accseq_chk u_chk (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ack(s_ack),
    .near_end_o(near_end_o), .end_o(end_o), .acc(acc_o), .flg(flag_o), .op(op_q)
);

// File: tb/sim_accseq_top.sv
`timescale 1ns/1ps
module sim_accseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ack;
    logic [15:0] acc_o;
    logic [3:0]  flag_o;
    logic        near_end_o, end_o;

    accseq_top u0 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ack(s_ack),
        .acc_o(acc_o), .flag_o(flag_o), .near_end_o(near_end_o), .end_o(end_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] acc;
        logic [3:0]  fl;
        int          start;
        int          lat;
        string       req;
    } item_t;

    item_t       sb[$];
    int          total = 0, bad = 0, cyc = 0, last_end = -1;
    logic [15:0] m_acc = 16'h0;
    logic [3:0]  m_fl = 4'h0;
    bit          pend = 0, done = 0;
    item_t       cur;

    always @(posedge clk) cyc <= cyc + 1;

    // bench reference: flags {ov, sign, zero, carry}
    task automatic model(input int op, input bit w, input int imm, input string req,
                         input int start, input int lat);
        int mask, msb, a, b, c, s, r;
        bit cf, ov;
        item_t it;
        mask = w ? 65535 : 255;
        msb  = w ? 32768 : 128;
        a = int'(m_acc) & mask;
        b = imm & mask;
        c = int'(m_fl[0]);
        cf = 0; ov = 0;
        case (op)
            0: s = a + b;
            2: s = a + b + c;
            3: s = a - b - c;
            5, 7: s = a - b;
            1: s = a | b;
            4: s = a & b;
            default: s = a ^ b;
        endcase
        r = s & mask;
        if (op == 0 || op == 2) begin
            cf = s > mask;
            ov = ((a ^ r) & (b ^ r) & msb) != 0;
        end else if (op == 3 || op == 5 || op == 7) begin
            cf = s < 0;
            ov = ((a ^ b) & (a ^ r) & msb) != 0;
        end
        m_fl = {ov, (r & msb) != 0, r == 0, cf};
        if (op != 7) m_acc = w ? 16'(r) : {m_acc[15:8], 8'(r)};
        it.acc = m_acc; it.fl = m_fl; it.start = start; it.lat = lat; it.req = req;
        sb.push_back(it);
    endtask

    task automatic send(input logic [7:0] b, output int at);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = b;
        #1;
        while (!s_ack) begin
            @(negedge clk);
            #1;
        end
        at = cyc;
    endtask

    task automatic issue(input int op, input bit w, input int imm, input int gap,
                         input string req);
        int t0, tx;
        send({2'b00, 3'(op), 2'b10, w}, t0);
        total++;
        if (last_end >= 0 && t0 != last_end) begin
            bad++;
            $display("FAIL R11 opcode taken at cycle %0d expected %0d", t0, last_end);
        end
        model(op, w, imm, req, t0, 4 + gap);
        repeat (gap) begin
            @(negedge clk);
            s_valid = 1'b0;
        end
        send(8'(imm), tx);
        if (w) send(8'(imm >> 8), tx);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (pend) begin
            pend = 0;
            total++;
            if (acc_o !== cur.acc || flag_o !== cur.fl) begin
                bad++;
                $display("FAIL %s acc=%h flags=%b expected acc=%h flags=%b",
                         cur.req, acc_o, flag_o, cur.acc, cur.fl);
            end
        end
        if (!rst && end_o === 1'b1) begin
            last_end = cyc;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R5 end pulse with no instruction pending: got 1 expected 0");
            end else begin
                cur = sb.pop_front();
                pend = 1;
                if (cyc - cur.start != cur.lat) begin
                    bad++;
                    $display("FAIL R5/R6/R7 (%s) latency=%0d expected %0d",
                             cur.req, cyc - cur.start, cur.lat);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        total++;
        if (acc_o !== 16'h0 || flag_o !== 4'h0 || end_o !== 1'b0 ||
            near_end_o !== 1'b0 || s_ack !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset acc=%h flags=%b end=%b near=%b ack=%b expected 0",
                     acc_o, flag_o, end_o, near_end_o, s_ack);
        end
        issue(0, 1, 16'h1234, 0, "R3 word add");
        issue(0, 1, 16'hEDCC, 0, "R8 word add carry/zero");
        issue(2, 0, 8'h05, 0, "R9 byte adc");
        issue(1, 1, 16'h8000, 0, "R8 or clears carry");
        issue(5, 0, 8'h07, 0, "R4 byte sub borrow");
        issue(3, 1, 16'h0001, 2, "R7 word sbb stalled");
        issue(6, 1, 16'h80FD, 0, "R8 xor zero");
        issue(0, 1, 16'h7FFF, 0, "R3 word add");
        issue(0, 1, 16'h0001, 0, "R8 word overflow");
        issue(7, 1, 16'h8000, 0, "R10 word compare");
        issue(4, 0, 8'h0F, 0, "R4 byte and");
        issue(0, 0, 8'h7F, 0, "R6 byte add");
        issue(0, 0, 8'h01, 0, "R8 byte overflow");
        issue(3, 0, 8'h10, 3, "R7 byte sbb stalled");
        issue(7, 0, 8'h55, 1, "R10 byte compare");
        issue(2, 1, 16'hFFFF, 0, "R9 word adc");
        @(negedge clk);
        s_valid = 1'b0;
        repeat (10) @(negedge clk);
        total++;
        if (sb.size() != 0 || pend) begin
            bad++;
            $display("FAIL R5 %0d results missing expected 0", sb.size());
        end
        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule